// File: doc/BRIEF.md
# Word Stack Push/Pop Sequencer

This block carries out 16-bit stack pushes and pops over a memory port that is one byte wide. It keeps the 16-bit stack pointer itself. Every byte address it issues is the stack segment value shifted left by four bits plus an offset taken from the stack pointer. Each word is split into two byte accesses in a fixed order. A push stores the high byte one below the pointer and the low byte two below it, then lowers the pointer by two. A pop reads the low byte at the pointer and the high byte one above it, then raises the pointer by two.

A requester raises `req_push` (with `push_data`) or `req_pop` for one cycle while `busy` is low. `done` rises for a single cycle when the operation is complete. In that cycle `sp` already shows the new pointer and, after a pop, `pop_data` holds the word. Memory reads return data one clock after the address is driven, and the sequencer waits for it.

The state machine has seven states:
- IDLE
- PUSH_HI: writes the high byte
- PUSH_LO: writes the low byte
- POP_LO: drives the low-byte address
- POP_HI: drives the high-byte address and takes the low byte
- POP_WAIT: takes the high byte
- FIN: completion

Its transitions are:
- IDLE→PUSH_HI on `req_push`
- IDLE→POP_LO on `req_pop` without `req_push`
- PUSH_HI→PUSH_LO
- PUSH_LO→FIN, which lowers the pointer
- POP_LO→POP_HI
- POP_HI→POP_WAIT
- POP_WAIT→FIN, which raises the pointer and loads `pop_data`
- FIN→IDLE

Top module: `stk_seq`

## Requirements
- R1: While reset is held and just after it is released, `sp` equals the parameter `SP_INIT`, and `busy`, `done` and `mem_we` are 0.
- R2: The first write of a push stores `push_data[15:8]` at offset SP-1.
- R3: The second write of a push, on the next cycle, stores `push_data[7:0]` at offset SP-2. A push makes exactly these two writes.
- R4: When a push completes, `sp` has decreased by 2.
- R5: A pop drives offset SP, then offset SP+1. It takes each byte one cycle after its address. On completion `pop_data` = {byte at SP+1, byte at SP}.
- R6: When a pop completes, `sp` has increased by 2, and the pop makes no memory write.
- R7: `mem_addr` = (`ss` × 16 + offset) modulo 2^20.
- R8: The pointer arithmetic wraps modulo 2^16, both for the byte offsets and for the final update.
- R9: Requests are taken only in IDLE. A request raised while `busy` is high has no effect. When both requests are raised together, the push is performed.
- R10: `done` is a one-cycle pulse. It comes 3 cycles after a push is taken and 4 cycles after a pop is taken. `busy` stays high from the cycle after acceptance through the `done` cycle.
- R11: `sp` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 1 | Start a word push (wins over `req_pop`) |
| req_pop | input | 1 | Start a word pop |
| push_data | input | 16 | Word to push, sampled when the request is taken |
| ss | input | 16 | Stack segment value |
| pop_data | output | 16 | Last popped word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read byte, valid one clock after `mem_addr` |

## Verification
The assertions that compare consecutive byte addresses assume `ss` stays constant from acceptance to `done`. They also assume that the memory answers every read one clock after the address. The directed bench changes `ss` only while the sequencer is idle. Its memory model registers the read byte on every edge, which gives exactly that one-clock latency. The address-step checks are also taken to apply only where the offset does not wrap inside a word. The stimulus drives inputs and samples outputs on the falling edge, so a request is always seen whole at the next rising edge.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_WAIT,
        ST_FIN
    } stk_state_e;

    typedef enum logic [1:0] {
        OFF_MINUS1,
        OFF_MINUS2,
        OFF_ZERO,
        OFF_PLUS1
    } stk_off_e;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int SEG_EXT_W = SEG_W + SEG_SHIFT;
    localparam int SUM_W     = (SEG_EXT_W > OFF_W) ? SEG_EXT_W : OFF_W;

    logic [SUM_W-1:0] seg_ext;
    logic [SUM_W-1:0] off_ext;
    logic [SUM_W-1:0] sum;

    assign seg_ext = SUM_W'({seg, {SEG_SHIFT{1'b0}}});
    assign off_ext = SUM_W'(off);
    assign sum     = seg_ext + off_ext;
    assign addr    = sum[ADDR_W-1:0];
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
    parameter int          SP_W    = 16,
    parameter logic [15:0] SP_INIT = 16'hFFFE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp
);
    localparam logic [SP_W-1:0] STEP = SP_W'(stk_pkg::WORD_W / stk_pkg::BYTE_W);

    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_W'(SP_INIT);
        else if (dec) sp <= sp - STEP;
        else if (inc) sp <= sp + STEP;
    end

    // R11: a single step direction per update
    a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc));
endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_push,
    input  logic       req_pop,
    output stk_state_e state,
    output logic       busy,
    output logic       done,
    output logic       mem_we,
    output stk_off_e   off_sel,
    output logic       wr_hi,
    output logic       take_req,
    output logic       cap_lo,
    output logic       cap_word,
    output logic       sp_dec,
    output logic       sp_inc
);
    stk_state_e next;

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:     if (req_push)     next = ST_PUSH_HI;
                         else if (req_pop) next = ST_POP_LO;
            ST_PUSH_HI:  next = ST_PUSH_LO;
            ST_PUSH_LO:  next = ST_FIN;
            ST_POP_LO:   next = ST_POP_HI;
            ST_POP_HI:   next = ST_POP_WAIT;
            ST_POP_WAIT: next = ST_FIN;
            ST_FIN:      next = ST_IDLE;
            default:     next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        mem_we   = 1'b0;
        off_sel  = OFF_ZERO;
        wr_hi    = 1'b0;
        take_req = 1'b0;
        cap_lo   = 1'b0;
        cap_word = 1'b0;
        sp_dec   = 1'b0;
        sp_inc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                take_req = req_push || req_pop;
            end
            ST_PUSH_HI: begin
                mem_we  = 1'b1;
                off_sel = OFF_MINUS1;
                wr_hi   = 1'b1;
            end
            ST_PUSH_LO: begin
                mem_we  = 1'b1;
                off_sel = OFF_MINUS2;
                sp_dec  = 1'b1;
            end
            ST_POP_LO:   off_sel = OFF_ZERO;
            ST_POP_HI: begin
                off_sel = OFF_PLUS1;
                cap_lo  = 1'b1;
            end
            ST_POP_WAIT: begin
                off_sel  = OFF_PLUS1;
                cap_word = 1'b1;
                sp_inc   = 1'b1;
            end
            ST_FIN:      done = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    // R10: completion lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: push wins over pop in IDLE
    a_r9_push_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_push) |=> state == ST_PUSH_HI);
    // R9: requests outside IDLE leave the sequence untouched
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |=> state == ST_PUSH_LO);
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int          SP_W      = 16,
    parameter int          SEG_W     = 16,
    parameter int          SEG_SHIFT = 4,
    parameter int          ADDR_W    = 20,
    parameter logic [15:0] SP_INIT   = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_push,
    input  logic              req_pop,
    input  logic [WORD_W-1:0] push_data,
    input  logic [SEG_W-1:0]  ss,
    output logic [WORD_W-1:0] pop_data,
    output logic              busy,
    output logic              done,
    output logic [SP_W-1:0]   sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [BYTE_W-1:0] mem_rdata
);
    stk_state_e        state;
    stk_off_e          off_sel;
    logic              wr_hi, take_req, cap_lo, cap_word, sp_dec, sp_inc;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] lo_q;
    logic [SP_W-1:0]   off;

    stk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_pop(req_pop),
        .state(state), .busy(busy), .done(done), .mem_we(mem_we),
        .off_sel(off_sel), .wr_hi(wr_hi), .take_req(take_req),
        .cap_lo(cap_lo), .cap_word(cap_word), .sp_dec(sp_dec), .sp_inc(sp_inc)
    );

    stk_sp_reg #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc), .sp(sp)
    );

    always_comb begin
        unique case (off_sel)
            OFF_MINUS1: off = sp - SP_W'(1);
            OFF_MINUS2: off = sp - SP_W'(2);
            OFF_PLUS1:  off = sp + SP_W'(1);
            default:    off = sp;
        endcase
    end

    stk_addr_gen #(.SEG_W(SEG_W), .OFF_W(SP_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_addr (
        .seg(ss), .off(off), .addr(mem_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            lo_q     <= '0;
            pop_data <= '0;
        end else begin
            if (take_req) word_q   <= push_data;
            if (cap_lo)   lo_q     <= mem_rdata;
            if (cap_word) pop_data <= {mem_rdata, lo_q};
        end
    end

    assign mem_wdata = wr_hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];

    // R3: second push byte lands one address below the first
    a_r3_lo_below_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && sp != SP_W'(1)) |-> mem_addr == $past(mem_addr) - ADDR_W'(1));
    // R5: pop high byte address one above the low byte address
    a_r5_pop_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_HI && sp != '1) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
    // R4: push completion lowers sp by two
    a_r4_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_we)) |-> sp == $past(sp) - SP_W'(2));
    // R6: pop completion raises sp by two
    a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(mem_we)) |-> sp == $past(sp) + SP_W'(2));
    // R11: sp moves only with done
    a_r11_sp_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> done);
    // R10: writes only occur while busy
    a_r10_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

// File: tb/stk_seq_bench.sv
module stk_seq_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] INIT_SP    = 16'h0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_push = 1'b0;
    logic        req_pop = 1'b0;
    logic [15:0] push_data = '0;
    logic [15:0] ss = 16'h1000;
    logic [15:0] pop_data;
    logic        busy, done, mem_we;
    logic [15:0] sp;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [0:4095];
    logic        pre_en = 1'b0;
    logic [11:0] pre_a = '0;
    logic [7:0]  pre_d = '0;
    logic [19:0] wlog_a [0:7];
    logic [7:0]  wlog_d [0:7];
    int          wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_seq #(.SP_INIT(INIT_SP)) u_stk_seq (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_pop(req_pop),
        .push_data(push_data), .ss(ss), .pop_data(pop_data), .busy(busy),
        .done(done), .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (pre_en) mem[pre_a] <= pre_d;
        else if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            wlog_a[wr_cnt[2:0]] <= mem_addr;
            wlog_d[wr_cnt[2:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_a = a[11:0]; pre_d = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Issue a request; return cycles until done is seen at a falling edge
    task automatic issue(input bit psh, input bit pp, input logic [15:0] d, output int lat);
        @(negedge clk);
        req_push = psh; req_pop = pp; push_data = d;
        lat = 0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            req_push = 1'b0; req_pop = 1'b0;
            if (done) begin lat = n; break; end
        end
    endtask

    task automatic t_reset();
        chk(sp == INIT_SP, "R1 sp", 32'(sp), 32'(INIT_SP));
        chk(!busy && !done && !mem_we, "R1 ctrl", {busy, done, mem_we}, 0);
    endtask

    task automatic t_push(input logic [15:0] d, input logic [15:0] sp0, input string tag);
        int lat, w0;
        w0 = wr_cnt;
        issue(1'b1, 1'b0, d, lat);
        chk(lat == 3, {tag, " R10 push latency"}, 32'(lat), 3);
        chk(wr_cnt - w0 == 2, {tag, " R3 write count"}, 32'(wr_cnt - w0), 2);
        chk(wlog_a[w0[2:0]] == (({ss, 4'h0} + {4'h0, 16'(sp0 - 16'd1)}) & 20'hFFFFF) && wlog_d[w0[2:0]] == d[15:8],
            {tag, " R2 high byte"}, {wlog_a[w0[2:0]], wlog_d[w0[2:0]]},
            {20'({ss, 4'h0} + {4'h0, 16'(sp0 - 16'd1)}), d[15:8]});
        chk(wlog_a[3'(w0 + 1)] == 20'({ss, 4'h0} + {4'h0, 16'(sp0 - 16'd2)}) && wlog_d[3'(w0 + 1)] == d[7:0],
            {tag, " R3 low byte"}, {wlog_a[3'(w0 + 1)], wlog_d[3'(w0 + 1)]},
            {20'({ss, 4'h0} + {4'h0, 16'(sp0 - 16'd2)}), d[7:0]});
        chk(sp == 16'(sp0 - 16'd2), {tag, " R4 sp after push"}, 32'(sp), 32'(16'(sp0 - 16'd2)));
    endtask

    task automatic t_pop(input logic [15:0] exp, input logic [15:0] sp0, input string tag);
        int lat, w0;
        w0 = wr_cnt;
        issue(1'b0, 1'b1, 16'h0, lat);
        chk(lat == 4, {tag, " R10 pop latency"}, 32'(lat), 4);
        chk(pop_data == exp, {tag, " R5 pop word"}, 32'(pop_data), 32'(exp));
        chk(sp == 16'(sp0 + 16'd2), {tag, " R6 sp after pop"}, 32'(sp), 32'(16'(sp0 + 16'd2)));
        chk(wr_cnt == w0, {tag, " R6 no write"}, 32'(wr_cnt - w0), 0);
    endtask

    task automatic t_priority();
        int lat, w0;
        logic [15:0] sp0;
        sp0 = sp; w0 = wr_cnt;
        @(negedge clk);
        req_push = 1'b1; req_pop = 1'b1; push_data = 16'h1357;
        @(negedge clk);
        req_push = 1'b0;
        lat = 1;
        for (int n = 2; n <= 12; n++) begin
            @(negedge clk);
            if (done) begin lat = n; break; end
        end
        req_pop = 1'b0;
        chk(lat == 3, "R9 push chosen latency", 32'(lat), 3);
        chk(wr_cnt - w0 == 2 && wlog_d[w0[2:0]] == 8'h13, "R9 push wins", 32'(wr_cnt - w0), 2);
        chk(sp == 16'(sp0 - 16'd2), "R9 sp after push", 32'(sp), 32'(16'(sp0 - 16'd2)));
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(!busy && !done && sp == 16'(sp0 - 16'd2), "R9 busy request ignored",
                {busy, done, sp}, {2'b00, 16'(sp0 - 16'd2)});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push(16'hA55A, 16'h0004, "T1");
        t_pop(16'hA55A, 16'h0002, "T2");
        preload(20'h10004, 8'hCD);
        preload(20'h10005, 8'hAB);
        t_pop(16'hABCD, 16'h0004, "T3");
        t_push(16'h1111, 16'h0006, "T4");
        t_push(16'h2222, 16'h0004, "T4");
        t_push(16'h3333, 16'h0002, "T4");
        t_push(16'hBEEF, 16'h0000, "R8 wrap down");
        t_pop(16'hBEEF, 16'hFFFE, "R8 wrap up");
        @(negedge clk);
        ss = 16'hFFFF;
        t_push(16'hC3A5, 16'h0000, "R7 addr wrap");
        chk(wlog_a[3'(wr_cnt - 2)] == 20'h0FFEF, "R7 20-bit wrap", 32'(wlog_a[3'(wr_cnt - 2)]), 32'h0FFEF);
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule